// File: doc/BRIEF.md
# Write Buffer with Read Bypass

This block sits between a write-through cache and main memory. The cache puts each store into a small queue. The queue sends its stores to memory in arrival order, using memory slots that no read needs. A read miss does not wait for the queue to empty. In the cycle it arrives, its address is compared against every occupied entry. If an entry matches, that entry's data answers the read at once and memory is not touched. If nothing matches, the read goes to memory ahead of every queued store.

The same path serves write-back replacement. The dirty victim is first pushed into the queue as an ordinary store. The demand read then goes to memory, and only after that is the victim written back. A store to an address already in the queue updates that entry in place and uses no new slot. When every slot is occupied, the full flag stalls the cache until an entry drains.

Top module: `wbuf_bypass`

## Requirements
- R1: After reset the queue is empty: `wr_full_o`, `mem_req_o` and `rd_done_o` are low while no read is presented.
- R2: With no read presented or outstanding and the queue non-empty, `mem_req_o` and `mem_we_o` are high and carry the oldest entry's address and data. The entry leaves on a cycle with `mem_ready_i` high, so stores reach memory one per accepted slot in arrival order.
- R3: A read presented while no read is outstanding, whose address matches no queued entry, drives `mem_req_o` high and `mem_we_o` low with `mem_addr_o` equal to the read address in the same cycle, even when stores are queued.
- R4: A read whose address matches a queued entry completes in the same cycle, with `rd_done_o` high, `rd_data_o` set to that entry's data and `mem_req_o` low.
- R5: After a read is accepted by memory, no store is drained until it completes. `rd_done_o` rises with `mem_rvalid_i`, and `rd_data_o` equals `mem_rdata_i`. The read request must be held until `rd_done_o`.
- R6: `wr_full_o` is high exactly when DEPTH entries are held. A store presented while it is high is discarded and leaves no entry behind.
- R7: A store whose address equals an entry that is not leaving memory in that cycle overwrites that entry's data and takes no new slot.
- R8: A victim store pushed into the queue, followed by a demand read to another address, sends the read to memory before the victim's write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Store from cache presented |
| wr_addr_i | input | ADDR_W | Store word address |
| wr_data_i | input | DATA_W | Store data |
| wr_full_o | output | 1 | All slots occupied; store not taken |
| rd_valid_i | input | 1 | Read miss presented, held until done |
| rd_addr_i | input | ADDR_W | Read word address |
| rd_done_o | output | 1 | Read data valid this cycle |
| rd_data_o | output | DATA_W | Forwarded or memory read data |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write (1) or a read (0) |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_ready_i | input | 1 | Memory accepts the request this cycle |
| mem_rvalid_i | input | 1 | Memory read data returned |
| mem_rdata_i | input | DATA_W | Memory read data |

## Verification
A corrupted head pointer or occupancy count shows at the memory port on the next drain cycle, as a wrong address or data, or as a request that is raised or missing. A stale valid or address bit in the compare appears in the very cycle a read is presented. It shows as a forward that should not happen, or as a memory read where a forward was due. A merge placed in the wrong slot remains hidden until that slot is read or drained. For that reason the bench also compares final memory contents against a reference after a long random run over a narrow address range.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  typedef enum logic {
    RD_IDLE = 1'b0,
    RD_WAIT = 1'b1
  } rd_state_e;
endpackage

// File: rtl/wbuf_match.sv
module wbuf_match #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 32
) (
  input  logic [DEPTH-1:0]             vld_i,
  input  logic [DEPTH-1:0]             excl_i,
  input  logic [DEPTH-1:0][ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0]            key_i,
  output logic                         hit_o,
  output logic [$clog2(DEPTH)-1:0]     idx_o
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [DEPTH-1:0] eq;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign eq[g] = vld_i[g] & ~excl_i[g] & (addr_i[g] == key_i);
  end

  // merging keeps addresses unique, so at most one bit is set
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (eq[i]) idx_o = IDX_W'(i);
    end
  end

  assign hit_o = |eq;
endmodule

// File: rtl/wbuf_store.sv
module wbuf_store #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             push_i,
  input  logic [ADDR_W-1:0]                push_addr_i,
  input  logic [DATA_W-1:0]                push_data_i,
  input  logic                             merge_i,
  input  logic [$clog2(DEPTH)-1:0]         merge_idx_i,
  input  logic [DATA_W-1:0]                merge_data_i,
  input  logic                             pop_i,
  output logic [DEPTH-1:0]                 vld_o,
  output logic [DEPTH-1:0][ADDR_W-1:0]     addr_o,
  output logic [DEPTH-1:0][DATA_W-1:0]     data_o,
  output logic [$clog2(DEPTH)-1:0]         head_idx_o,
  output logic [$clog2(DEPTH):0]           cnt_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [PTR_W-1:0]               head_q, tail_q;
  logic [CNT_W-1:0]               cnt_q;
  logic [DEPTH-1:0][ADDR_W-1:0]   addr_q;
  logic [DEPTH-1:0][DATA_W-1:0]   data_q;

  // DEPTH must be a power of two: pointers wrap by overflow
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_q + PTR_W'(pop_i);
      tail_q <= tail_q + PTR_W'(push_i);
      cnt_q  <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      addr_q[tail_q] <= push_addr_i;
      data_q[tail_q] <= push_data_i;
    end
    if (merge_i) data_q[merge_idx_i] <= merge_data_i;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_vld
    logic [PTR_W-1:0] off;
    assign off      = PTR_W'(g) - head_q;
    assign vld_o[g] = CNT_W'(off) < cnt_q;
  end

  assign addr_o     = addr_q;
  assign data_o     = data_q;
  assign head_idx_o = head_q;
  assign cnt_o      = cnt_q;
endmodule

// File: rtl/wbuf_bypass.sv
module wbuf_bypass #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_full_o,
  input  logic              rd_valid_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              rd_done_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  import wbuf_pkg::*;

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  rd_state_e rd_state_q, rd_state_d;

  logic [DEPTH-1:0]             vld;
  logic [DEPTH-1:0][ADDR_W-1:0] addrs;
  logic [DEPTH-1:0][DATA_W-1:0] datas;
  logic [PTR_W-1:0]             head_idx, rd_idx, wm_idx;
  logic [CNT_W-1:0]             cnt;
  logic                         rd_hit, wm_hit;
  logic                         rd_wait, rd_pend, rd_fwd, rd_miss;
  logic                         drain, wr_acc;
  logic [DEPTH-1:0]             wr_excl;

  assign rd_wait = (rd_state_q == RD_WAIT);
  assign rd_pend = rd_valid_i | rd_wait;
  assign rd_fwd  = rd_valid_i & ~rd_wait & rd_hit;
  assign rd_miss = rd_valid_i & ~rd_wait & ~rd_hit;

  assign wr_full_o = (cnt == CNT_W'(DEPTH));
  assign wr_acc    = wr_valid_i & ~wr_full_o;

  assign mem_we_o    = ~rd_pend & (cnt != '0);
  assign mem_req_o   = rd_miss | mem_we_o;
  assign mem_addr_o  = rd_miss ? rd_addr_i : addrs[head_idx];
  assign mem_wdata_o = datas[head_idx];
  assign drain       = mem_we_o & mem_ready_i;

  // an entry leaving this cycle cannot absorb a merge
  assign wr_excl = drain ? (DEPTH'(1) << head_idx) : '0;

  assign rd_done_o = rd_fwd | (rd_wait & mem_rvalid_i);
  assign rd_data_o = rd_fwd ? datas[rd_idx] : mem_rdata_i;

  wbuf_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_rd_match (
    .vld_i  (vld),
    .excl_i ('0),
    .addr_i (addrs),
    .key_i  (rd_addr_i),
    .hit_o  (rd_hit),
    .idx_o  (rd_idx)
  );

  wbuf_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_wr_match (
    .vld_i  (vld),
    .excl_i (wr_excl),
    .addr_i (addrs),
    .key_i  (wr_addr_i),
    .hit_o  (wm_hit),
    .idx_o  (wm_idx)
  );

  wbuf_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (wr_acc & ~wm_hit),
    .push_addr_i  (wr_addr_i),
    .push_data_i  (wr_data_i),
    .merge_i      (wr_acc & wm_hit),
    .merge_idx_i  (wm_idx),
    .merge_data_i (wr_data_i),
    .pop_i        (drain),
    .vld_o        (vld),
    .addr_o       (addrs),
    .data_o       (datas),
    .head_idx_o   (head_idx),
    .cnt_o        (cnt)
  );

  always_comb begin
    rd_state_d = rd_state_q;
    unique case (rd_state_q)
      RD_IDLE: if (rd_miss && mem_ready_i) rd_state_d = RD_WAIT;
      RD_WAIT: if (mem_rvalid_i) rd_state_d = RD_IDLE;
      default: rd_state_d = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_state_q <= RD_IDLE;
    else         rd_state_q <= rd_state_d;
  end
endmodule

// File: rtl/wbuf_bypass_chk.sv
module wbuf_bypass_chk #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_valid_i,
  input logic              wr_full_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ready_i,
  input logic              rd_wait_i,
  input logic              rd_fwd_i,
  input logic [CNT_W-1:0]  cnt_i
);
  // R6
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CNT_W'(DEPTH));

  // R6
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_full_o && !(mem_req_o && mem_we_o && mem_ready_i) |=> wr_full_o);

  // R4
  fwd_no_mem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_fwd_i |-> !mem_req_o);

  // R3
  read_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i && !rd_wait_i && !rd_fwd_i |-> mem_req_o && !mem_we_o);

  // R5
  no_drain_in_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_wait_i |-> !(mem_req_o && mem_we_o));

  // R2
  drain_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_i && !rd_wait_i && (cnt_i != '0) |-> mem_req_o && mem_we_o);

  // R2
  head_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && !mem_ready_i |=> !(mem_req_o && mem_we_o) || $stable(mem_addr_o));
endmodule

bind wbuf_bypass wbuf_bypass_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_valid_i  (rd_valid_i),
  .wr_full_o   (wr_full_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_ready_i (mem_ready_i),
  .rd_wait_i   (rd_wait),
  .rd_fwd_i    (rd_fwd),
  .cnt_i       (cnt)
);

// File: tb/wbuf_bypass_test.sv
module wbuf_bypass_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 4;
  localparam int AW     = 6;
  localparam int DW     = 16;
  localparam int RD_LAT = 3;
  localparam int WDOG   = 100000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          rst_ni;
  logic          wr_valid_i, rd_valid_i, mem_ready_i, mem_rvalid_i;
  logic [AW-1:0] wr_addr_i, rd_addr_i;
  logic [DW-1:0] wr_data_i, mem_rdata_i;
  logic          wr_full_o, rd_done_o, mem_req_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] rd_data_o, mem_wdata_o;

  wbuf_bypass #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .wr_valid_i(wr_valid_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .wr_full_o(wr_full_o),
    .rd_valid_i(rd_valid_i), .rd_addr_i(rd_addr_i), .rd_done_o(rd_done_o), .rd_data_o(rd_data_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_ready_i(mem_ready_i), .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i)
  );

  int checks = 0;
  int fails  = 0;
  int qa[$];
  int qd[$];
  bit m_wait = 0;
  int bmem[64];
  int gmem[64];
  int pend_cnt = 0;
  int pend_addr = 0;

  function automatic int init_val(int a);
    return (a * 37 + 5) & 16'hFFFF;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // memory response for this cycle, then let outputs settle
  task automatic pre();
    mem_rvalid_i = (pend_cnt == 1);
    mem_rdata_i  = (pend_cnt == 1) ? DW'(bmem[pend_addr]) : '0;
    #1;
  endtask

  // compare against the reference, advance one edge, update reference
  task automatic post();
    bit e_full, e_req, e_we, e_done, pop, acc;
    int e_addr, e_wdata, e_rdata, hit, found;
    bit s_ready, s_rvalid, s_wr, a_wr, a_rd;
    int s_waddr, s_wdata, a_addr, a_data;
    string mt, dt;
    e_full = (qa.size() == DEPTH);
    e_req = 0; e_we = 0; e_done = 0; e_addr = 0; e_wdata = 0; e_rdata = 0; hit = -1;
    foreach (qa[k]) if (qa[k] == int'(rd_addr_i)) hit = k;
    mt = "R2"; dt = "R5";
    if (rd_valid_i && !m_wait) begin
      if (hit >= 0) begin e_done = 1; e_rdata = qd[hit]; dt = "R4"; mt = "R4"; end
      else begin e_req = 1; e_addr = int'(rd_addr_i); mt = "R3"; end
    end else if (m_wait) begin
      e_done = mem_rvalid_i; e_rdata = int'(mem_rdata_i); mt = "R5";
    end else if (qa.size() > 0) begin
      e_req = 1; e_we = 1; e_addr = qa[0]; e_wdata = qd[0];
    end
    check(wr_full_o == e_full, "R6", wr_full_o, e_full);
    check(mem_req_o == e_req, mt, mem_req_o, e_req);
    if (e_req) begin
      check(mem_we_o == e_we, mt, mem_we_o, e_we);
      check(int'(mem_addr_o) == e_addr, mt, mem_addr_o, e_addr);
      if (e_we) check(int'(mem_wdata_o) == e_wdata, "R2", mem_wdata_o, e_wdata);
    end
    check(rd_done_o == e_done, dt, rd_done_o, e_done);
    if (e_done) check(int'(rd_data_o) == e_rdata, dt, rd_data_o, e_rdata);
    s_ready = mem_ready_i; s_rvalid = mem_rvalid_i; s_wr = wr_valid_i;
    s_waddr = int'(wr_addr_i); s_wdata = int'(wr_data_i);
    a_wr = mem_req_o && mem_we_o && mem_ready_i;
    a_rd = mem_req_o && !mem_we_o && mem_ready_i;
    a_addr = int'(mem_addr_o); a_data = int'(mem_wdata_o);
    @(posedge clk);
    if (a_wr) bmem[a_addr] = a_data;
    if (pend_cnt == 1) pend_cnt = 0;
    else if (pend_cnt > 1) pend_cnt--;
    if (a_rd) begin pend_cnt = RD_LAT; pend_addr = a_addr; end
    if (e_req && !e_we && s_ready) m_wait = 1;
    else if (m_wait && s_rvalid) m_wait = 0;
    pop = e_req && e_we && s_ready;
    acc = s_wr && !e_full;
    found = -1;
    if (acc) for (int k = (pop ? 1 : 0); k < qa.size(); k++) if (qa[k] == s_waddr) found = k;
    if (found >= 0) qd[found] = s_wdata;
    if (pop) begin
      gmem[qa[0]] = qd[0];
      void'(qa.pop_front());
      void'(qd.pop_front());
    end
    if (acc && found < 0) begin qa.push_back(s_waddr); qd.push_back(s_wdata); end
    @(negedge clk);
  endtask

  task automatic cyc();
    pre();
    post();
  endtask

  task automatic wait_rd(input int exp);
    bit done;
    done = 0;
    for (int n = 0; n < 20 && !done; n++) begin
      pre();
      if (rd_done_o) begin
        done = 1;
        check(int'(rd_data_o) == exp, "R5", rd_data_o, exp);
      end else begin
        check(!(mem_req_o && mem_we_o), "R5", mem_we_o, 0);
      end
      post();
    end
    check(done, "R5", done, 1);
    rd_valid_i = 0;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog expired actual=%0d expected=%0d", WDOG, 0);
    summary();
  end

  initial begin
    for (int a = 0; a < 64; a++) begin bmem[a] = init_val(a); gmem[a] = init_val(a); end
    rst_ni = 0; wr_valid_i = 0; rd_valid_i = 0; mem_ready_i = 0;
    wr_addr_i = '0; wr_data_i = '0; rd_addr_i = '0; mem_rvalid_i = 0; mem_rdata_i = '0;
    repeat (3) @(negedge clk);
    #1;
    check(!wr_full_o, "R1", wr_full_o, 0);
    check(!mem_req_o, "R1", mem_req_o, 0);
    check(!rd_done_o, "R1", rd_done_o, 0);
    @(negedge clk);
    rst_ni = 1;

    // fill with memory stalled
    for (int i = 0; i < 4; i++) begin
      wr_valid_i = 1; wr_addr_i = AW'(i + 1); wr_data_i = DW'(100 + i);
      cyc();
    end
    wr_valid_i = 0;
    pre(); check(wr_full_o, "R6", wr_full_o, 1); post();
    wr_valid_i = 1; wr_addr_i = 9; wr_data_i = 555;
    cyc();
    wr_valid_i = 0;

    // forward from a queued entry
    rd_valid_i = 1; rd_addr_i = 3;
    pre();
    check(rd_done_o && int'(rd_data_o) == 102, "R4", rd_data_o, 102);
    check(!mem_req_o, "R4", mem_req_o, 0);
    post();
    rd_valid_i = 0;

    // miss goes ahead of a full queue
    rd_valid_i = 1; rd_addr_i = 10; mem_ready_i = 1;
    pre();
    check(mem_req_o && !mem_we_o && mem_addr_o == 10, "R3", mem_addr_o, 10);
    post();
    wait_rd(init_val(10));

    // store taken while full must be absent
    rd_valid_i = 1; rd_addr_i = 9; mem_ready_i = 0;
    pre();
    check(mem_req_o && !mem_we_o && !rd_done_o, "R6", rd_done_o, 0);
    post();
    mem_ready_i = 1;
    cyc();
    wait_rd(init_val(9));

    // drain one, then merge into a queued entry
    pre(); check(mem_we_o && mem_addr_o == 1, "R2", mem_addr_o, 1); post();
    mem_ready_i = 0;
    wr_valid_i = 1; wr_addr_i = 3; wr_data_i = 777;
    cyc();
    wr_valid_i = 0;
    pre(); check(!wr_full_o, "R7", wr_full_o, 0); post();
    rd_valid_i = 1; rd_addr_i = 3;
    pre(); check(rd_done_o && int'(rd_data_o) == 777, "R7", rd_data_o, 777); post();
    rd_valid_i = 0;
    mem_ready_i = 1;
    pre(); check(mem_we_o && mem_addr_o == 2, "R2", mem_addr_o, 2); post();
    pre(); check(mem_we_o && mem_addr_o == 3 && mem_wdata_o == 777, "R2", mem_wdata_o, 777); post();
    pre(); check(mem_we_o && mem_addr_o == 4, "R2", mem_addr_o, 4); post();
    pre(); check(!mem_req_o, "R2", mem_req_o, 0); post();

    // dirty victim parked, demand read first, then write-back
    wr_valid_i = 1; wr_addr_i = 20; wr_data_i = 4242;
    cyc();
    wr_valid_i = 0;
    rd_valid_i = 1; rd_addr_i = 21;
    pre(); check(mem_req_o && !mem_we_o && mem_addr_o == 21, "R8", mem_addr_o, 21); post();
    wait_rd(init_val(21));
    pre(); check(mem_we_o && mem_addr_o == 20 && mem_wdata_o == 4242, "R8", mem_wdata_o, 4242); post();
    cyc();

    // random traffic over a narrow address range
    for (int n = 0; n < 3000; n++) begin
      bit clr;
      pre();
      clr = rd_valid_i && rd_done_o;
      post();
      if (clr) rd_valid_i = 0;
      wr_valid_i  = ($urandom_range(0, 99) < 45);
      wr_addr_i   = AW'($urandom_range(0, 11));
      wr_data_i   = DW'($urandom_range(0, 65535));
      mem_ready_i = ($urandom_range(0, 99) < 65);
      if (!rd_valid_i && !clr && $urandom_range(0, 99) < 20) begin
        rd_valid_i = 1;
        rd_addr_i  = AW'($urandom_range(0, 11));
      end
    end
    wr_valid_i = 0; mem_ready_i = 1;
    for (int n = 0; n < 40; n++) begin
      bit clr;
      pre();
      clr = rd_valid_i && rd_done_o;
      post();
      if (clr) rd_valid_i = 0;
    end
    begin
      int bad;
      bad = 0;
      for (int a = 0; a < 64; a++) if (bmem[a] != gmem[a]) bad++;
      check(bad == 0, "R2", bad, 0);
    end
    check(qa.size() == 0 && !mem_req_o, "R2", qa.size(), 0);
    summary();
  end
endmodule